// File: doc/BRIEF.md
# Clock Page-Replacement Controller

This block picks the physical frame that receives a page on a hard miss. It manages a fixed pool of frames, 16 by default. While some frames are still unused, each fault takes the next free frame in order. Once every frame holds a page, the block runs the second-chance clock policy. A circular hand walks the frames. It clears and skips each frame whose reference mark is set, and it stops at the first frame whose mark is clear. If the chosen frame is dirty, the block asks an external storage model to write that page back before it asks for the incoming page to be loaded. It then tells the page tables to map the new page and to drop the page it displaced.

The translation logic calls the block in two ways. It raises a fault request with the missing virtual page number and waits for a done pulse. It also pulses an access strobe, carrying the frame and a write flag, for every processed access. Those strobes set the per-frame reference and dirty marks that the block keeps. Every fifth strobe clears all reference marks and emits a global clear to the page table and the translation cache. For each fault the block reports whether a page was evicted and whether that page was dirty. A reverse map from frame to virtual page lets it name the displaced page.

Top module: `clock_evict_ctrl`

## Requirements
- R1: While fewer than NUM_FRAMES frames hold pages, a fault takes the lowest unused frame (0, then 1, and so on), evicts nothing and raises no write-back.
- R2: With all frames used, the hand starts at frame 0 after reset and examines one frame per cycle. It goes upward and wraps from NUM_FRAMES-1 to 0. A frame with its reference mark set has the mark cleared and is skipped. The first frame with a clear mark becomes the victim, and the hand then points one past it.
- R3: A write-back is requested only when the victim's dirty mark is set. wb_req stays high, with the victim frame and the evicted page number, until wb_ack. The load starts only after that.
- R4: In the cycle of wb_ack, dirty_clr_vld pulses with the evicted page number, and the frame's dirty mark is cleared.
- R5: On every fifth acc_vld pulse counted since reset, ref_clr is high in that same cycle and every reference mark is cleared, including the mark of that fifth access.
- R6: flt_done pulses for one cycle at the end of each fault. In that cycle flt_frame carries the frame used, flt_evicted is 1 if a page was displaced, flt_evict_dirty is 1 if that page was dirty, and flt_victim_vpn holds its page number.
- R7: When a page is displaced, pt_inval_vld pulses in the flt_done cycle with that page number in pt_inval_vpn.
- R8: ld_req stays high with the target frame and the requested page until ld_ack. In the flt_done cycle, pt_map_vld pulses with the new page and frame. The installed frame gets its reference mark set and its dirty mark cleared.
- R9: After reset, every strobe and request output is low and the controller waits for a fault.
- R10: acc_vld sets the reference mark of acc_frame. When acc_write is also high, it sets that frame's dirty mark as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flt_req | input | 1 | Hard-miss request, held until flt_done |
| flt_vpn | input | VPN_W | Missing virtual page number |
| flt_done | output | 1 | Fault serviced, one-cycle pulse |
| flt_frame | output | FRAME_W | Frame that received the page |
| flt_evicted | output | 1 | A page was displaced |
| flt_evict_dirty | output | 1 | The displaced page was dirty |
| flt_victim_vpn | output | VPN_W | Page number of the displaced page |
| wb_req | output | 1 | Write-back request to storage |
| wb_frame | output | FRAME_W | Frame to write back |
| wb_vpn | output | VPN_W | Page being written back |
| wb_ack | input | 1 | Write-back complete |
| ld_req | output | 1 | Load request to storage |
| ld_frame | output | FRAME_W | Frame to fill |
| ld_vpn | output | VPN_W | Page to load |
| ld_ack | input | 1 | Load complete |
| pt_map_vld | output | 1 | Map strobe for the incoming page |
| pt_map_vpn | output | VPN_W | Incoming page number |
| pt_map_frame | output | FRAME_W | Frame of the incoming page |
| pt_inval_vld | output | 1 | Invalidate strobe for the displaced page and its cached copy |
| pt_inval_vpn | output | VPN_W | Displaced page number |
| dirty_clr_vld | output | 1 | Dirty mark cleared after write-back |
| dirty_clr_vpn | output | VPN_W | Page whose dirty mark was cleared |
| acc_vld | input | 1 | One processed access |
| acc_frame | input | FRAME_W | Frame touched by the access |
| acc_write | input | 1 | The access was a write |
| ref_clr | output | 1 | Global reference-mark clear |

## Verification
The bench builds the block with its default parameters: 16 frames, 8-bit page numbers and a clear period of five accesses. With 16 frames, seventeen faults are enough to move from filling free frames to clock eviction. A full sweep of the hand, wrapping from frame 15 back to frame 0 when every mark is set, can be reached right after the pool fills. A period of five lets a short run of accesses land the global clear just before a fault. That makes visible both the skip-and-clear sweep and a scan that stops at once on a dirty frame. Storage acknowledgements with varying delays show that the requests are held until acknowledged.

// File: rtl/clock_evict_pkg.sv
package clock_evict_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SELECT = 3'd1,
    ST_WB     = 3'd2,
    ST_LOAD   = 3'd3,
    ST_UPDATE = 3'd4
  } evict_st_e;
endpackage

// File: rtl/clock_evict_rst_sync.sv
module clock_evict_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/clock_evict_marks.sv
module clock_evict_marks #(
  parameter int NUM_FRAMES = 16,
  parameter int PERIOD     = 5,
  localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_vld,
  input  logic [FW-1:0]         acc_frame,
  input  logic                  acc_write,
  input  logic                  skip_clr,
  input  logic [FW-1:0]         skip_frame,
  input  logic                  install,
  input  logic [FW-1:0]         inst_frame,
  input  logic                  wb_done,
  input  logic [FW-1:0]         wb_frame,
  output logic [NUM_FRAMES-1:0] ref_vec,
  output logic [NUM_FRAMES-1:0] dirty_vec,
  output logic                  ref_clr
);
  logic [NUM_FRAMES-1:0] ref_q, ref_n, dirty_q, dirty_n;
  logic [CW-1:0]         cnt_q, cnt_n;
  logic                  period_wrap;
  logic                  ref_en, dirty_en;

  assign period_wrap = acc_vld && (cnt_q == CW'(PERIOD - 1));

  always_comb begin
    cnt_n = cnt_q;
    if (acc_vld) cnt_n = period_wrap ? '0 : cnt_q + CW'(1);
  end

  for (genvar gi = 0; gi < NUM_FRAMES; gi++) begin : g_frame
    always_comb begin
      ref_n[gi] = ref_q[gi];
      if (skip_clr && skip_frame == FW'(gi)) ref_n[gi] = 1'b0;
      if (install  && inst_frame == FW'(gi)) ref_n[gi] = 1'b1;
      if (acc_vld  && acc_frame  == FW'(gi)) ref_n[gi] = 1'b1;
      if (period_wrap)                       ref_n[gi] = 1'b0;
    end
    always_comb begin
      dirty_n[gi] = dirty_q[gi];
      if (wb_done && wb_frame   == FW'(gi))             dirty_n[gi] = 1'b0;
      if (install && inst_frame == FW'(gi))             dirty_n[gi] = 1'b0;
      if (acc_vld && acc_write && acc_frame == FW'(gi)) dirty_n[gi] = 1'b1;
    end
  end

  assign ref_en   = skip_clr | install | acc_vld;
  assign dirty_en = wb_done | install | (acc_vld & acc_write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      dirty_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (ref_en)   ref_q   <= ref_n;
      if (dirty_en) dirty_q <= dirty_n;
      if (acc_vld)  cnt_q   <= cnt_n;
    end
  end

  assign ref_vec   = ref_q;
  assign dirty_vec = dirty_q;
  assign ref_clr   = period_wrap;

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(PERIOD));

  // R5
  ref_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clr |=> (ref_q == '0));

  // R4
  dirty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_done && !(acc_vld && acc_write)) |=> !dirty_q[$past(wb_frame)]);

  // R10
  acc_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_write) |=> dirty_q[$past(acc_frame)]);
endmodule

// File: rtl/clock_evict_rmap.sv
module clock_evict_rmap #(
  parameter int NUM_FRAMES = 16,
  parameter int VPN_W      = 8,
  localparam int FW  = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int FCW = $clog2(NUM_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             install,
  input  logic [FW-1:0]    inst_frame,
  input  logic [VPN_W-1:0] inst_vpn,
  input  logic [FW-1:0]    rd_frame,
  output logic [VPN_W-1:0] rd_vpn,
  output logic             full,
  output logic [FW-1:0]    fill_frame
);
  logic [VPN_W-1:0] owner_q [NUM_FRAMES];
  logic [FCW-1:0]   fill_q;
  logic             fill_en;

  assign full       = (fill_q == FCW'(NUM_FRAMES));
  assign fill_frame = fill_q[FW-1:0];
  assign fill_en    = install && !full;

  always_ff @(posedge clk) begin
    if (install) owner_q[inst_frame] <= inst_vpn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill_q <= '0;
    else if (fill_en) fill_q <= fill_q + FCW'(1);
  end

  assign rd_vpn = owner_q[rd_frame];

  // R1
  free_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (install && !full) |-> (inst_frame == fill_frame));
endmodule

// File: rtl/clock_evict_fsm.sv
module clock_evict_fsm
  import clock_evict_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  parameter int VPN_W      = 8,
  localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flt_req,
  input  logic [VPN_W-1:0]      flt_vpn,
  input  logic                  full,
  input  logic [FW-1:0]         fill_frame,
  input  logic [NUM_FRAMES-1:0] ref_vec,
  input  logic [NUM_FRAMES-1:0] dirty_vec,
  input  logic [VPN_W-1:0]      rd_vpn,
  input  logic                  wb_ack,
  input  logic                  ld_ack,
  output logic [FW-1:0]         hand,
  output logic                  skip_clr,
  output logic                  install,
  output logic [FW-1:0]         vic_frame,
  output logic [VPN_W-1:0]      new_vpn,
  output logic                  evicted,
  output logic                  vic_dirty,
  output logic [VPN_W-1:0]      vic_vpn,
  output logic                  wb_req,
  output logic                  wb_done,
  output logic                  ld_req
);
  evict_st_e        st_q, st_n;
  logic [VPN_W-1:0] vpn_q, vpn_n, vvpn_q, vvpn_n;
  logic [FW-1:0]    vic_q, vic_n, hand_q, hand_n, hand_inc;
  logic             evict_q, evict_n, vdirty_q, vdirty_n;
  logic             reg_en;

  assign hand_inc = (hand_q == FW'(NUM_FRAMES - 1)) ? '0 : hand_q + FW'(1);

  always_comb begin
    st_n     = st_q;
    vpn_n    = vpn_q;
    vic_n    = vic_q;
    evict_n  = evict_q;
    vdirty_n = vdirty_q;
    vvpn_n   = vvpn_q;
    hand_n   = hand_q;
    skip_clr = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (flt_req) begin
          vpn_n = flt_vpn;
          st_n  = ST_SELECT;
        end
      end
      ST_SELECT: begin
        if (!full) begin
          vic_n    = fill_frame;
          evict_n  = 1'b0;
          vdirty_n = 1'b0;
          st_n     = ST_LOAD;
        end else if (ref_vec[hand_q]) begin
          skip_clr = 1'b1;
          hand_n   = hand_inc;
        end else begin
          vic_n    = hand_q;
          evict_n  = 1'b1;
          vdirty_n = dirty_vec[hand_q];
          vvpn_n   = rd_vpn;
          hand_n   = hand_inc;
          st_n     = dirty_vec[hand_q] ? ST_WB : ST_LOAD;
        end
      end
      ST_WB:     if (wb_ack) st_n = ST_LOAD;
      ST_LOAD:   if (ld_ack) st_n = ST_UPDATE;
      ST_UPDATE: st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  assign reg_en = (st_q != ST_IDLE) || flt_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      vpn_q    <= '0;
      vic_q    <= '0;
      evict_q  <= 1'b0;
      vdirty_q <= 1'b0;
      vvpn_q   <= '0;
      hand_q   <= '0;
    end else if (reg_en) begin
      st_q     <= st_n;
      vpn_q    <= vpn_n;
      vic_q    <= vic_n;
      evict_q  <= evict_n;
      vdirty_q <= vdirty_n;
      vvpn_q   <= vvpn_n;
      hand_q   <= hand_n;
    end
  end

  assign hand      = hand_q;
  assign install   = (st_q == ST_UPDATE);
  assign vic_frame = vic_q;
  assign new_vpn   = vpn_q;
  assign evicted   = evict_q;
  assign vic_dirty = vdirty_q;
  assign vic_vpn   = vvpn_q;
  assign wb_req    = (st_q == ST_WB);
  assign wb_done   = (st_q == ST_WB) && wb_ack;
  assign ld_req    = (st_q == ST_LOAD);

  // R3
  wb_needs_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (vic_dirty && evicted));

  // R3
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(vic_frame)));

  // R8
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !ld_ack) |=> (ld_req && $stable(new_vpn)));

  // R6
  dirty_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (install && vic_dirty) |-> evicted);

  // R2
  skip_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_clr |=> (hand != $past(hand)));
endmodule

// File: rtl/clock_evict_ctrl.sv
module clock_evict_ctrl #(
  parameter int NUM_FRAMES = 16,
  parameter int VPN_W      = 8,
  parameter int PERIOD     = 5,
  localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_req,
  input  logic [VPN_W-1:0] flt_vpn,
  output logic             flt_done,
  output logic [FW-1:0]    flt_frame,
  output logic             flt_evicted,
  output logic             flt_evict_dirty,
  output logic [VPN_W-1:0] flt_victim_vpn,
  output logic             wb_req,
  output logic [FW-1:0]    wb_frame,
  output logic [VPN_W-1:0] wb_vpn,
  input  logic             wb_ack,
  output logic             ld_req,
  output logic [FW-1:0]    ld_frame,
  output logic [VPN_W-1:0] ld_vpn,
  input  logic             ld_ack,
  output logic             pt_map_vld,
  output logic [VPN_W-1:0] pt_map_vpn,
  output logic [FW-1:0]    pt_map_frame,
  output logic             pt_inval_vld,
  output logic [VPN_W-1:0] pt_inval_vpn,
  output logic             dirty_clr_vld,
  output logic [VPN_W-1:0] dirty_clr_vpn,
  input  logic             acc_vld,
  input  logic [FW-1:0]    acc_frame,
  input  logic             acc_write,
  output logic             ref_clr
);
  logic                  rst_sn;
  logic [NUM_FRAMES-1:0] ref_vec, dirty_vec;
  logic [FW-1:0]         hand, vic_frame, fill_frame;
  logic [VPN_W-1:0]      new_vpn, vic_vpn, rd_vpn;
  logic                  skip_clr, install, evicted, vic_dirty, wb_done, full;

  clock_evict_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sn)
  );

  clock_evict_fsm #(.NUM_FRAMES(NUM_FRAMES), .VPN_W(VPN_W)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_sn),
    .flt_req    (flt_req),
    .flt_vpn    (flt_vpn),
    .full       (full),
    .fill_frame (fill_frame),
    .ref_vec    (ref_vec),
    .dirty_vec  (dirty_vec),
    .rd_vpn     (rd_vpn),
    .wb_ack     (wb_ack),
    .ld_ack     (ld_ack),
    .hand       (hand),
    .skip_clr   (skip_clr),
    .install    (install),
    .vic_frame  (vic_frame),
    .new_vpn    (new_vpn),
    .evicted    (evicted),
    .vic_dirty  (vic_dirty),
    .vic_vpn    (vic_vpn),
    .wb_req     (wb_req),
    .wb_done    (wb_done),
    .ld_req     (ld_req)
  );

  clock_evict_marks #(.NUM_FRAMES(NUM_FRAMES), .PERIOD(PERIOD)) i_marks (
    .clk        (clk),
    .rst_n      (rst_sn),
    .acc_vld    (acc_vld),
    .acc_frame  (acc_frame),
    .acc_write  (acc_write),
    .skip_clr   (skip_clr),
    .skip_frame (hand),
    .install    (install),
    .inst_frame (vic_frame),
    .wb_done    (wb_done),
    .wb_frame   (vic_frame),
    .ref_vec    (ref_vec),
    .dirty_vec  (dirty_vec),
    .ref_clr    (ref_clr)
  );

  clock_evict_rmap #(.NUM_FRAMES(NUM_FRAMES), .VPN_W(VPN_W)) i_rmap (
    .clk        (clk),
    .rst_n      (rst_sn),
    .install    (install),
    .inst_frame (vic_frame),
    .inst_vpn   (new_vpn),
    .rd_frame   (hand),
    .rd_vpn     (rd_vpn),
    .full       (full),
    .fill_frame (fill_frame)
  );

  assign flt_done        = install;
  assign flt_frame       = vic_frame;
  assign flt_evicted     = evicted;
  assign flt_evict_dirty = vic_dirty;
  assign flt_victim_vpn  = vic_vpn;
  assign wb_frame        = vic_frame;
  assign wb_vpn          = vic_vpn;
  assign ld_frame        = vic_frame;
  assign ld_vpn          = new_vpn;
  assign pt_map_vld      = install;
  assign pt_map_vpn      = new_vpn;
  assign pt_map_frame    = vic_frame;
  assign pt_inval_vld    = install && evicted;
  assign pt_inval_vpn    = vic_vpn;
  assign dirty_clr_vld   = wb_done;
  assign dirty_clr_vpn   = vic_vpn;

  // R7
  inval_with_map_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    pt_inval_vld |-> (pt_map_vld && flt_evicted));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    flt_done |=> !flt_done);
endmodule

// File: tb/test_clock_evict_ctrl.sv
`timescale 1ns/1ps
module test_clock_evict_ctrl;
  localparam int NF = 16;
  localparam int VW = 8;
  localparam int FW = 4;
  localparam int PER = 5;

  logic clk, rst_n;
  logic flt_req; logic [VW-1:0] flt_vpn;
  logic flt_done, flt_evicted, flt_evict_dirty; logic [FW-1:0] flt_frame; logic [VW-1:0] flt_victim_vpn;
  logic wb_req, wb_ack, ld_req, ld_ack;
  logic [FW-1:0] wb_frame, ld_frame, pt_map_frame, acc_frame;
  logic [VW-1:0] wb_vpn, ld_vpn, pt_map_vpn, pt_inval_vpn, dirty_clr_vpn;
  logic pt_map_vld, pt_inval_vld, dirty_clr_vld, acc_vld, acc_write, ref_clr;

  clock_evict_ctrl #(.NUM_FRAMES(NF), .VPN_W(VW), .PERIOD(PER)) i_clock_evict_ctrl (
    .clk(clk), .rst_n(rst_n), .flt_req(flt_req), .flt_vpn(flt_vpn),
    .flt_done(flt_done), .flt_frame(flt_frame), .flt_evicted(flt_evicted),
    .flt_evict_dirty(flt_evict_dirty), .flt_victim_vpn(flt_victim_vpn),
    .wb_req(wb_req), .wb_frame(wb_frame), .wb_vpn(wb_vpn), .wb_ack(wb_ack),
    .ld_req(ld_req), .ld_frame(ld_frame), .ld_vpn(ld_vpn), .ld_ack(ld_ack),
    .pt_map_vld(pt_map_vld), .pt_map_vpn(pt_map_vpn), .pt_map_frame(pt_map_frame),
    .pt_inval_vld(pt_inval_vld), .pt_inval_vpn(pt_inval_vpn),
    .dirty_clr_vld(dirty_clr_vld), .dirty_clr_vpn(dirty_clr_vpn),
    .acc_vld(acc_vld), .acc_frame(acc_frame), .acc_write(acc_write), .ref_clr(ref_clr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int ncmp = 0;
  int nmis = 0;
  bit finished = 0;
  int unsigned lcg = 32'h1234_5678;

  task automatic chk(input string tag, input int got, input int exp);
    ncmp++;
    if (got !== exp) begin
      nmis++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int rnd(input int m);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) % m);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nmis);
      $finish;
    end
  endtask

  // behavioural reference model, evaluated once per cycle
  int m_ph = 0;          // 0 idle 1 scan 2 wb 3 load 4 update
  int m_ref[NF], m_dirty[NF], m_owner[NF];
  int m_fill = 0, m_hand = 0, m_cnt = 0;
  int m_vpn = 0, m_vic = 0, m_ev = 0, m_vd = 0, m_vvpn = 0;
  initial for (int i = 0; i < NF; i++) begin m_ref[i] = 0; m_dirty[i] = 0; m_owner[i] = 0; end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int nph, wrap;
      nph = m_ph;
      wrap = (acc_vld && m_cnt == PER - 1) ? 1 : 0;
      chk("R5 ref_clr", int'(ref_clr), wrap);
      chk("R3 wb_req", int'(wb_req), (m_ph == 2) ? 1 : 0);
      chk("R8 ld_req", int'(ld_req), (m_ph == 3) ? 1 : 0);
      chk("R6 flt_done", int'(flt_done), (m_ph == 4) ? 1 : 0);
      chk("R8 pt_map_vld", int'(pt_map_vld), (m_ph == 4) ? 1 : 0);
      chk("R7 pt_inval_vld", int'(pt_inval_vld), (m_ph == 4 && m_ev == 1) ? 1 : 0);
      chk("R4 dirty_clr_vld", int'(dirty_clr_vld), (m_ph == 2 && wb_ack) ? 1 : 0);
      if (m_ph == 2) begin
        chk("R3 wb_frame", int'(wb_frame), m_vic);
        chk("R3 wb_vpn", int'(wb_vpn), m_vvpn);
        if (wb_ack) chk("R4 dirty_clr_vpn", int'(dirty_clr_vpn), m_vvpn);
      end
      if (m_ph == 3) begin
        chk("R8 ld_frame", int'(ld_frame), m_vic);
        chk("R8 ld_vpn", int'(ld_vpn), m_vpn);
      end
      if (m_ph == 4) begin
        chk("R2 flt_frame", int'(flt_frame), m_vic);
        chk("R6 flt_evicted", int'(flt_evicted), m_ev);
        chk("R6 flt_evict_dirty", int'(flt_evict_dirty), m_vd);
        chk("R8 pt_map_vpn", int'(pt_map_vpn), m_vpn);
        chk("R8 pt_map_frame", int'(pt_map_frame), m_vic);
        if (m_ev == 1) begin
          chk("R6 flt_victim_vpn", int'(flt_victim_vpn), m_vvpn);
          chk("R7 pt_inval_vpn", int'(pt_inval_vpn), m_vvpn);
        end
      end
      // next state
      case (m_ph)
        0: if (flt_req) begin m_vpn = int'(flt_vpn); nph = 1; end
        1: begin
          if (m_fill < NF) begin
            m_vic = m_fill; m_ev = 0; m_vd = 0; nph = 3;
          end else if (m_ref[m_hand] != 0) begin
            m_ref[m_hand] = 0; m_hand = (m_hand + 1) % NF;
          end else begin
            m_vic = m_hand; m_ev = 1; m_vd = m_dirty[m_hand]; m_vvpn = m_owner[m_hand];
            m_hand = (m_hand + 1) % NF;
            nph = (m_vd != 0) ? 2 : 3;
          end
        end
        2: if (wb_ack) begin m_dirty[m_vic] = 0; nph = 3; end
        3: if (ld_ack) nph = 4;
        4: begin
          m_owner[m_vic] = m_vpn; m_dirty[m_vic] = 0; m_ref[m_vic] = 1;
          if (m_ev == 0) m_fill++;
          nph = 0;
        end
        default: nph = 0;
      endcase
      if (acc_vld) begin
        m_ref[int'(acc_frame)] = 1;
        if (acc_write) m_dirty[int'(acc_frame)] = 1;
        m_cnt = (wrap != 0) ? 0 : m_cnt + 1;
      end
      if (wrap != 0) for (int i = 0; i < NF; i++) m_ref[i] = 0;
      m_ph = nph;
    end
  end

  // storage responder with varying delays
  int wcnt = 0, wdly = 1, lcnt = 0, ldly = 0;
  initial begin
    wb_ack = 1'b0; ld_ack = 1'b0;
    forever begin
      @(posedge clk); #1;
      wb_ack = 1'b0; ld_ack = 1'b0;
      if (wb_req) begin
        if (wcnt >= wdly) begin wb_ack = 1'b1; wcnt = 0; wdly = rnd(4); end
        else wcnt++;
      end
      if (ld_req) begin
        if (lcnt >= ldly) begin ld_ack = 1'b1; lcnt = 0; ldly = rnd(4); end
        else lcnt++;
      end
    end
  end

  // captured results of the last fault
  int c_frame, c_ev, c_vd, c_vvpn, c_inv, c_wb, c_wbvpn, c_dclr;

  task automatic do_fault(input int vpn);
    flt_req = 1'b1; flt_vpn = VW'(vpn);
    c_wb = 0; c_dclr = 0; c_wbvpn = -1;
    forever begin
      @(negedge clk);
      if (wb_req) begin c_wb = 1; c_wbvpn = int'(wb_vpn); end
      if (dirty_clr_vld) c_dclr = 1;
      if (flt_done) break;
    end
    c_frame = int'(flt_frame); c_ev = int'(flt_evicted); c_vd = int'(flt_evict_dirty);
    c_vvpn = int'(flt_victim_vpn); c_inv = int'(pt_inval_vpn);
    @(posedge clk); #1;
    flt_req = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic do_acc(input int frame, input int wr);
    acc_vld = 1'b1; acc_frame = FW'(frame); acc_write = wr[0];
    @(posedge clk); #1;
    acc_vld = 1'b0; acc_write = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nmis++;
    $display("FAIL R6 watchdog: actual hung expected flt_done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; flt_req = 1'b0; flt_vpn = '0;
    acc_vld = 1'b0; acc_frame = '0; acc_write = 1'b0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 flt_done", int'(flt_done), 0);
    chk("R9 wb_req", int'(wb_req), 0);
    chk("R9 ld_req", int'(ld_req), 0);
    chk("R9 pt_map_vld", int'(pt_map_vld), 0);
    chk("R9 ref_clr", int'(ref_clr), 0);
    @(posedge clk); #1;

    // R1 free frames in order
    for (int i = 0; i < NF; i++) begin
      do_fault(10 + i);
      chk("R1 free frame", c_frame, i);
      chk("R1 no eviction", c_ev, 0);
      chk("R1 no write-back", c_wb, 0);
    end

    // R2 all marks set: full sweep wraps back to frame 0
    do_fault(40);
    chk("R2 wrap victim", c_frame, 0);
    chk("R6 victim vpn", c_vvpn, 10);
    chk("R7 inval vpn", c_inv, 10);
    chk("R3 clean no wb", c_wb, 0);

    // R10 marks from accesses, R2 skipping
    do_acc(1, 1); do_acc(2, 1); do_acc(3, 0); do_acc(4, 0);
    do_fault(41);
    chk("R2 skip to frame", c_frame, 5);
    chk("R6 clean report", c_vd, 0);

    // R5 fifth access clears marks; R10 dirty frame 6
    acc_vld = 1'b1; acc_frame = FW'(6); acc_write = 1'b1;
    @(negedge clk);
    chk("R5 fifth access clear", int'(ref_clr), 1);
    @(posedge clk); #1;
    acc_vld = 1'b0; acc_write = 1'b0;
    do_fault(42);
    chk("R2 stop at hand", c_frame, 6);
    chk("R6 dirty report", c_vd, 1);
    chk("R3 wb issued", c_wb, 1);
    chk("R3 wb vpn", c_wbvpn, 16);
    chk("R4 dirty clear seen", c_dclr, 1);

    // mixed traffic, checked by the model
    for (int k = 0; k < 40; k++) begin
      int na;
      na = rnd(7);
      for (int a = 0; a < na; a++) do_acc(rnd(NF), rnd(2));
      do_fault(100 + k);
    end

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule